// File: doc/BRIEF.md
# Serial Asynchronous Transmitter with Line-Break Sequencing

This block turns bytes into asynchronous serial frames on a single output line. Each frame is a low start bit, eight data bits sent least significant bit first, an optional parity bit and a high stop bit. Every bit lasts one period of the external `baud_tick` strobe, and each tick moves the frame forward by one bit. A one-entry holding register takes bytes through a valid/ready write port. The register hands its byte to the shift stage at the next bit boundary, so a byte written while another byte is shifting goes out directly after it, with no idle bit between them.

Two single-cycle command pulses control a break, which is a long low level on the line. A break request does not interrupt a frame in progress. The break starts only after that frame's stop bit. It lasts at least one full frame time, which is ten bit times without parity and eleven with parity. An early release request is remembered and takes effect when that minimum has elapsed. A later release request ends the break at the next bit boundary. After a break the line is high for at least one bit time before any new start bit. Further break requests are ignored while a break is pending or in progress.

The sequencer has seven states. `ST_IDLE`, `ST_STOP` and `ST_MARK` are launch points: on a tick each goes to `ST_BREAK` if a break is pending, else to `ST_START` if the holding register is full (this loads the byte), else to `ST_IDLE`. `ST_START` goes to `ST_DATA` on a tick. `ST_DATA` stays for eight ticks, then goes to `ST_PARITY` when parity is enabled, or to `ST_STOP` when it is not. `ST_PARITY` goes to `ST_STOP`. `ST_BREAK` goes to `ST_MARK` on the first tick where the minimum count has been reached and a release request is latched.

Top module: `uart_brk_tx`

## Requirements
- R1: After reset, `txd` is 1, `wr_ready`, `hold_empty` and `tx_empty` are 1, and `brk_active` is 0.
- R2: A frame is one 0 start bit, then data bits 0 through 7 in that order, then an optional parity bit, then a 1 stop bit. Each bit lasts exactly one `baud_tick` period.
- R3: `par_mode` selects parity. 2'b00 and 2'b11 mean no parity bit (10-bit frame). 2'b01 means even parity: the parity bit is the XOR of the data bits. 2'b10 means odd parity: the parity bit is the inverted XOR of the data bits (11-bit frame in both cases).
- R4: A write is accepted only while `wr_ready` is 1. While the holding register is full, `wr_ready` and `hold_empty` are 0 and the held byte does not change. A byte held when a stop bit ends starts on the very next bit, with no idle bit.
- R5: A `brk_start` pulse during a frame lets that frame finish, including its stop bit, before the line goes low.
- R6: If `brk_stop` arrives before the minimum has elapsed, the break lasts exactly one frame length: 10 bit times, or 11 with parity.
- R7: The break holds the line low until `brk_stop` arrives. A `brk_stop` that arrives after the minimum ends the break at the next tick. A `brk_stop` issued while no break is pending or active is ignored.
- R8: `brk_start` pulses are ignored while a break is pending or active, so they neither add a second break nor lengthen the current one.
- R9: After a break, the line is high for at least one bit time before the next start bit. A byte written during a break is sent after that break.
- R10: `brk_active` is 1 exactly while the break holds the line low. `tx_empty` is 1 only when the sequencer is idle, the holding register is empty and no break is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle strobe, one per bit time |
| par_mode | input | 2 | Parity select (00 none, 01 even, 10 odd, 11 none) |
| wr_valid | input | 1 | Write request for the holding register |
| wr_data | input | 8 | Byte to send |
| wr_ready | output | 1 | Holding register can accept a byte |
| brk_start | input | 1 | Pulse: request a break |
| brk_stop | input | 1 | Pulse: request release of the break |
| txd | output | 1 | Serial line, high when idle |
| hold_empty | output | 1 | Holding register is empty |
| tx_empty | output | 1 | Nothing held, shifting or pending |
| brk_active | output | 1 | Break is driving the line low |

## Verification
The assertions assume that `baud_tick`, `brk_start` and `brk_stop` are single-cycle pulses, that ticks are at least two clocks apart, and that `par_mode` changes only while `tx_empty` is 1, since the minimum break count depends on it. The stimulus drives every input at the falling clock edge and spaces ticks four clocks apart. It changes parity only after waiting for the transmitter to drain. Each release pulse is placed between two ticks, counted from the rise of `brk_active`, so that the exact break length can be predicted.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_BREAK,
        ST_MARK
    } tx_state_e;

    localparam logic [1:0] PAR_EVEN = 2'b01;
    localparam logic [1:0] PAR_ODD  = 2'b10;

    function automatic logic parity_on(input logic [1:0] mode);
        return (mode == PAR_EVEN) || (mode == PAR_ODD);
    endfunction

endpackage

// File: rtl/tx_holding_reg.sv
module tx_holding_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    output logic          wr_ready,
    input  logic          take,
    output logic [DW-1:0] hold_data,
    output logic          hold_full
);

    logic [DW-1:0] data_q;
    logic          full_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (take) begin
            full_q <= 1'b0;
        end else if (wr_valid && !full_q) begin
            full_q <= 1'b1;
            data_q <= wr_data;
        end
    end

    always_comb begin
        wr_ready  = !full_q;
        hold_full = full_q;
        hold_data = data_q;
    end

    // R4: a full register keeps its byte until the sequencer takes it
    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !take) |=> (full_q && $stable(data_q)));

endmodule

// File: rtl/tx_break_ctl.sv
module tx_break_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic brk_start,
    input  logic brk_stop,
    input  logic in_break,
    input  logic brk_enter,
    input  logic brk_exit,
    output logic brk_pend,
    output logic stop_req
);

    logic pend_q;
    logic stop_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (brk_enter) begin
            pend_q <= 1'b0;
        end else if (brk_start && !pend_q && !in_break) begin
            pend_q <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stop_q <= 1'b0;
        end else if (brk_exit) begin
            stop_q <= 1'b0;
        end else if (brk_stop && (pend_q || in_break)) begin
            stop_q <= 1'b1;
        end
    end

    always_comb begin
        brk_pend = pend_q;
        stop_req = stop_q;
    end

    // R8: a break only begins from an accepted, pending request
    assert_enter_from_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_break) |-> $past(pend_q));

    // R8: no new request is queued while a break holds the line
    assert_no_pend_in_break_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_break && !brk_exit) |=> !pend_q);

endmodule

// File: rtl/tx_sequencer.sv
module tx_sequencer
    import uart_brk_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          hold_full,
    input  logic [DW-1:0] hold_data,
    input  logic          brk_pend,
    input  logic          stop_req,
    output logic          take,
    output logic          brk_enter,
    output logic          brk_exit,
    output logic          in_break,
    output logic          line_idle,
    output logic          txd
);

    localparam int BW = (DW > 1) ? $clog2(DW) : 1;

    tx_state_e     state_q, state_d;
    logic [DW-1:0] shift_q;
    logic          par_q;
    logic [BW-1:0] bit_q;
    logic [CW-1:0] brk_cnt_q;
    logic [CW-1:0] char_len;

    assign char_len = par_en ? CW'(DW + 3) : CW'(DW + 2);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and handshake pulses
    always_comb begin
        state_d   = state_q;
        take      = 1'b0;
        brk_enter = 1'b0;
        brk_exit  = 1'b0;
        if (tick) begin
            unique case (state_q)
                ST_IDLE, ST_STOP, ST_MARK: begin
                    if (brk_pend) begin
                        state_d   = ST_BREAK;
                        brk_enter = 1'b1;
                    end else if (hold_full) begin
                        state_d = ST_START;
                        take    = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
                ST_START:  state_d = ST_DATA;
                ST_DATA: begin
                    if (bit_q == BW'(DW - 1))
                        state_d = par_en ? ST_PARITY : ST_STOP;
                end
                ST_PARITY: state_d = ST_STOP;
                ST_BREAK: begin
                    if ((brk_cnt_q >= char_len) && stop_req) begin
                        state_d  = ST_MARK;
                        brk_exit = 1'b1;
                    end
                end
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // datapath: shift register, parity, bit and break counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q   <= '0;
            par_q     <= 1'b0;
            bit_q     <= '0;
            brk_cnt_q <= '0;
        end else begin
            if (take) begin
                shift_q <= hold_data;
                par_q   <= (^hold_data) ^ par_odd;
            end else if (tick && state_q == ST_DATA) begin
                shift_q <= shift_q >> 1;
            end
            if (tick && state_q == ST_START)
                bit_q <= '0;
            else if (tick && state_q == ST_DATA)
                bit_q <= bit_q + 1'b1;
            if (brk_enter)
                brk_cnt_q <= CW'(1);
            else if (tick && state_q == ST_BREAK && brk_cnt_q != '1)
                brk_cnt_q <= brk_cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_START, ST_BREAK:        txd = 1'b0;
            ST_DATA:                   txd = shift_q[0];
            ST_PARITY:                 txd = par_q;
            default:                   txd = 1'b1;
        endcase
        in_break  = (state_q == ST_BREAK);
        line_idle = (state_q == ST_IDLE);
    end

    // R6: a break never leaves before the minimum frame count
    assert_min_break_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_break) |-> ($past(brk_cnt_q) >= $past(char_len)));

    // R7: with release latched and minimum reached, the next tick ends the break
    assert_late_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_break && tick && stop_req && brk_cnt_q >= char_len) |=> !in_break);

    // R9: a break is always followed by a high mark bit
    assert_mark_after_break_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_break) |-> (txd && state_q == ST_MARK));

endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx
    import uart_brk_pkg::*;
#(
    parameter int DW = 8,
    localparam int CW = $clog2(DW + 4)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic [1:0]    par_mode,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    output logic          wr_ready,
    input  logic          brk_start,
    input  logic          brk_stop,
    output logic          txd,
    output logic          hold_empty,
    output logic          tx_empty,
    output logic          brk_active
);

    logic          take, brk_enter, brk_exit, in_break, line_idle;
    logic          hold_full, brk_pend, stop_req;
    logic [DW-1:0] hold_data;

    tx_holding_reg #(.DW(DW)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .wr_ready  (wr_ready),
        .take      (take),
        .hold_data (hold_data),
        .hold_full (hold_full)
    );

    tx_break_ctl u_brk (
        .clk       (clk),
        .rst_n     (rst_n),
        .brk_start (brk_start),
        .brk_stop  (brk_stop),
        .in_break  (in_break),
        .brk_enter (brk_enter),
        .brk_exit  (brk_exit),
        .brk_pend  (brk_pend),
        .stop_req  (stop_req)
    );

    tx_sequencer #(.DW(DW), .CW(CW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .par_en    (parity_on(par_mode)),
        .par_odd   (par_mode == PAR_ODD),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .brk_pend  (brk_pend),
        .stop_req  (stop_req),
        .take      (take),
        .brk_enter (brk_enter),
        .brk_exit  (brk_exit),
        .in_break  (in_break),
        .line_idle (line_idle),
        .txd       (txd)
    );

    always_comb begin
        hold_empty = !hold_full;
        brk_active = in_break;
        tx_empty   = line_idle && !hold_full && !brk_pend;
    end

    // R10: the break indication implies a low line
    assert_break_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        brk_active |-> !txd);

    // R10: empty implies a high line, nothing held, no break
    assert_empty_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> (txd && hold_empty && !brk_active));

    // R5: a break starts only after a high bit (stop, mark or idle)
    assert_break_after_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_active) |-> $past(txd));

endmodule

// File: tb/test_uart_brk_tx.sv
module test_uart_brk_tx;

    typedef struct {
        bit       is_brk;
        bit [7:0] data;
        int       len;
        int       gapm;
        string    req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic [1:0] par_mode = 2'b00;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_ready;
    logic       brk_start = 1'b0;
    logic       brk_stop = 1'b0;
    logic       txd, hold_empty, tx_empty, brk_active;

    int n_cmp = 0;
    int n_err = 0;
    bit done  = 0;
    exp_t q[$];

    uart_brk_tx i_uart_brk_tx (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .par_mode(par_mode),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .brk_start(brk_start), .brk_stop(brk_stop), .txd(txd),
        .hold_empty(hold_empty), .tx_empty(tx_empty), .brk_active(brk_active)
    );

    always #5 clk = ~clk;

    int tdiv = 0;
    always @(negedge clk) begin
        baud_tick = rst_n && (tdiv == 3);
        tdiv = (tdiv + 1) % 4;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int frame_len();
        return (par_mode == 2'b01 || par_mode == 2'b10) ? 11 : 10;
    endfunction

    // ---------------- monitor ----------------
    int        pos = -1;
    logic [10:0] fr = '0;
    int        hi_run = 100;
    int        lo_run = 0;
    bit        in_brk = 0;

    task automatic got_char(input logic [7:0] d, input logic pbit, input int gap);
        exp_t e;
        if (q.size() == 0) begin
            chk(0, "R2", "unexpected char", d, 0);
            return;
        end
        e = q.pop_front();
        chk(!e.is_brk && e.data == d, e.req, "char data", d, e.data);
        if (frame_len() == 11)
            chk(pbit == ((^d) ^ (par_mode == 2'b10)), "R3", "parity bit",
                pbit, (^d) ^ (par_mode == 2'b10));
        if (e.gapm == 1) chk(gap == 0, e.req, "idle bits before start", gap, 0);
        if (e.gapm == 2) chk(gap >= 1, e.req, "mark bits after break", gap, 1);
    endtask

    task automatic got_break(input int len);
        exp_t e;
        if (q.size() == 0) begin
            chk(0, "R8", "unexpected break", len, 0);
            return;
        end
        e = q.pop_front();
        chk(e.is_brk, e.req, "break expected", 1, e.is_brk);
        if (e.len > 0) chk(len == e.len, e.req, "break length", len, e.len);
        else           chk(len >= frame_len(), e.req, "break min", len, frame_len());
    endtask

    task automatic mon_bit(input logic b);
        int fl;
        fl = frame_len();
        if (in_brk) begin
            if (!b) lo_run++;
            else begin
                got_break(lo_run);
                in_brk = 0;
                hi_run = 1;
            end
        end else if (pos < 0) begin
            if (b) hi_run++;
            else begin
                fr = '0;
                pos = 1;
            end
        end else begin
            fr[pos] = b;
            pos++;
            if (pos == fl) begin
                if (fr[fl-1]) begin
                    got_char(fr[8:1], fr[9], hi_run);
                    hi_run = 0;
                end else begin
                    in_brk = 1;
                    lo_run = fl;
                end
                pos = -1;
            end
        end
    endtask

    always @(posedge clk) begin
        if (rst_n && baud_tick) begin
            #1;
            mon_bit(txd);
        end
    end

    // ---------------- driver ----------------
    task automatic write_byte(input logic [7:0] d, input int gapm, input string req);
        exp_t e;
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        e.is_brk = 0; e.data = d; e.len = 0; e.gapm = gapm; e.req = req;
        q.push_back(e);
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic expect_break(input int len, input string req);
        exp_t e;
        e.is_brk = 1; e.data = 0; e.len = len; e.gapm = 0; e.req = req;
        q.push_back(e);
    endtask

    task automatic pulse_start();
        @(negedge clk); brk_start = 1'b1;
        @(negedge clk); brk_start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); brk_stop = 1'b1;
        @(negedge clk); brk_stop = 1'b0;
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (!baud_tick) @(posedge clk);
        end
    endtask

    task automatic wait_break_rise();
        @(posedge clk);
        while (!brk_active) @(posedge clk);
    endtask

    task automatic drain();
        @(negedge clk);
        while (q.size() != 0 || !tx_empty) @(negedge clk);
        wait_ticks(2);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(txd == 1'b1, "R1", "txd", txd, 1);
        chk(wr_ready && hold_empty && tx_empty, "R1", "ready/empty",
            {wr_ready, hold_empty, tx_empty}, 3'b111);
        chk(brk_active == 1'b0, "R1", "brk_active", brk_active, 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(txd == 1'b1, "R1", "txd idle after reset", txd, 1);

        // R2: plain framing, no parity
        write_byte(8'hA5, 0, "R2");
        drain();

        // R4: holding register with back-to-back frames
        write_byte(8'h3C, 0, "R4");
        write_byte(8'h81, 1, "R4");
        @(negedge clk);
        chk(!wr_ready && !hold_empty, "R4", "full while shifting",
            {wr_ready, hold_empty}, 2'b00);
        drain();

        // R3: parity modes
        par_mode = 2'b01;
        write_byte(8'h07, 0, "R3");
        write_byte(8'h03, 0, "R3");
        drain();
        par_mode = 2'b10;
        write_byte(8'h00, 0, "R3");
        write_byte(8'hFF, 0, "R3");
        drain();
        par_mode = 2'b11;
        write_byte(8'h55, 0, "R3");
        drain();

        // R5, R6, R8, R9: break requested mid-frame, early release
        par_mode = 2'b00;
        write_byte(8'hF0, 0, "R5");
        expect_break(10, "R6");
        wait_ticks(3);
        pulse_start();
        chk(brk_active == 1'b0, "R5", "frame not cut", brk_active, 0);
        pulse_stop();
        pulse_start();
        pulse_start();
        wait_break_rise();
        @(negedge clk);
        chk(txd == 1'b0 && !tx_empty, "R10", "line low, not empty in break",
            {txd, tx_empty}, 2'b00);
        write_byte(8'h5A, 2, "R9");
        pulse_start();
        wait_ticks(3);
        pulse_start();
        drain();
        chk(brk_active == 1'b0 && txd == 1'b1, "R8", "single break only",
            {brk_active, txd}, 2'b01);

        // R6: minimum with parity, requested from idle
        par_mode = 2'b01;
        expect_break(11, "R6");
        pulse_start();
        pulse_stop();
        drain();

        // R7: late release ends at next tick
        par_mode = 2'b00;
        expect_break(15, "R7");
        pulse_start();
        wait_break_rise();
        wait_ticks(14);
        @(negedge clk);
        chk(brk_active == 1'b1, "R7", "holds past minimum", brk_active, 1);
        pulse_stop();
        drain();

        // R7: stray release while idle is ignored
        pulse_stop();
        expect_break(13, "R7");
        pulse_start();
        wait_break_rise();
        wait_ticks(12);
        pulse_stop();
        drain();

        // R10: empty and high at the end
        chk(tx_empty && txd && !brk_active, "R10", "final idle",
            {tx_empty, txd, brk_active}, 3'b110);
        chk(q.size() == 0, "R2", "scoreboard drained", q.size(), 0);
        finish_run();
    end

endmodule